// File: doc/BRIEF.md
# Steerable PWM Generator with Dead-Band and Bridge Outputs

This block produces one pulse-width-modulated waveform from an 8-bit period timer extended by a 2-bit sub-count, then routes that waveform to one, two or four output pins. A 2-bit output-mode field chooses the routing and also decides which pin enables are asserted. In two-pin mode the second pin carries the complement of the first. Every rising edge on either pin is held back by a programmable number of clocks, so the two pins are never high together. In four-pin mode the block drives a full bridge. One corner is held on and the diagonal corner is modulated; a direction bit chooses which diagonal.

A 4-bit function field turns the generator on. A shutdown input forces all pins low on the next clock. The pins then stay low until the first period start after the shutdown is released. Period and duty values written at any time are held back until the running period ends, so a period is never cut short or stretched by a write.

Top module: `pwm_steer`

## Requirements
- R1: The generator runs only while `ctl_func[3:2]` is 2'b11. For any other value the counter stays at zero, and every `pwm_o` and `pwm_oe` bit is 0 from the next clock.
- R2: Pin index 0..3 is pin A..D. While running, `pwm_oe` becomes 4'b0001 for `out_mode` 2'b00, 4'b0011 for 2'b10, and 4'b1111 for 2'b01 or 2'b11.
- R3: One period lasts 4*(`period_i`+1) clocks. The waveform is high while the 10-bit count (timer value times 4 plus sub-count) is below `duty_i`. A duty of 0 gives a constant low, and a duty at or above the period length gives a constant high.
- R4: New `period_i` and `duty_i` values take effect only at the next period rollover. A duty change in mid-period does not change the current period.
- R5: In mode 2'b00, pin A carries the waveform. Pins B, C and D stay low.
- R6: In mode 2'b10, pin A carries the waveform and pin B its complement. Each rising edge of either pin is delayed by `dband_i` clocks, and the two pins are never high at the same time.
- R7: In four-pin mode with `bridge_rev`=0, pin A is high, pin D carries the waveform, and pins B and C are low.
- R8: In four-pin mode with `bridge_rev`=1, pin C is high, pin B carries the waveform, and pins A and D are low.
- R9: While `shdn_i` is 1, all pins are low from the next clock on. After release, the pins stay low until the next period start.
- R10: While `rst_n` is low, and after it is released with the generator off, all `pwm_o` and `pwm_oe` bits are 0.
- R11: A pin whose enable is 0 always has its output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_func | input | 4 | Function field; bits 3:2 = 2'b11 runs the generator |
| out_mode | input | 2 | Output routing: 00 one pin, 10 two pins, x1 four pins |
| bridge_rev | input | 1 | Bridge direction in four-pin mode (0 forward, 1 reverse) |
| period_i | input | 8 | Period timer terminal value |
| duty_i | input | 10 | Duty in clocks (timer value times 4 plus sub-count) |
| dband_i | input | 6 | Dead-band delay in clocks for two-pin mode |
| shdn_i | input | 1 | Shutdown request, forces all pins low |
| pwm_o | output | 4 | Pin outputs A..D (bit 0 = A) |
| pwm_oe | output | 4 | Pin enables A..D (bit 0 = A) |

## Verification
The bench counts high cycles on each pin over exactly one period, so an off-by-one period length, a wrong comparison at duty 0 or at a duty beyond the period, or a dead band that trims the wrong edge or the wrong number of clocks shows up as a wrong count. A duty change in mid-period checks that the design holds it back until rollover; a design that applies it at once would give extra high cycles in the current period. Shutdown is asserted while pin A is high. A design that only masks the pins while the input is held would resume in mid-period and fail the zero count that follows. The bridge cases in both directions catch a swapped diagonal, and the two-pin cases catch any cycle in which A and B overlap.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int unsigned NPIN = 4;

  // Pin enable pattern for a routing mode: x1 -> four pins, 10 -> two, 00 -> one
  function automatic logic [NPIN-1:0] pin_mask(input logic [1:0] mode);
    if (mode[0])      return 4'b1111;
    else if (mode[1]) return 4'b0011;
    else              return 4'b0001;
  endfunction

  function automatic logic is_quad(input logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic is_dual(input logic [1:0] mode);
    return mode == 2'b10;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned PER_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [PER_W-1:0]          period_i,
  input  logic [PER_W+FRAC_W-1:0]   duty_i,
  output logic                      raw_o,
  output logic                      wrap_o
);
  localparam int unsigned CNT_W = PER_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             load;

  assign wrap_o = run && (cnt_q == {per_q, {FRAC_W{1'b1}}});
  // shadows follow the inputs while idle and at each rollover
  assign load   = !run || wrap_o;
  assign raw_o  = run && (cnt_q < duty_q);

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (!run || wrap_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
    if (load) begin
      per_d  = period_i;
      duty_d = duty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int unsigned DB_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_i,
  input  logic [DB_W-1:0] dband_i,
  output logic            pos_o,
  output logic            neg_o
);
  logic            raw_q;
  logic [DB_W-1:0] gap_q, gap_d;
  logic            flip, gap_now;

  assign flip = raw_i ^ raw_q;
  // the gap covers dband_i clocks starting with the cycle of the change
  assign gap_now = flip ? (dband_i != '0) : (gap_q != '0);
  assign pos_o = raw_i && !gap_now;
  assign neg_o = !raw_i && !gap_now;

  always_comb begin
    gap_d = gap_q;
    if (flip)              gap_d = (dband_i == '0) ? '0 : dband_i - 1'b1;
    else if (gap_q != '0)  gap_d = gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      gap_q <= '0;
    end else begin
      raw_q <= raw_i;
      gap_q <= gap_d;
    end
  end
endmodule

// File: rtl/pwm_outsel.sv
module pwm_outsel
  import pwm_steer_pkg::*;
(
  input  logic [1:0]      mode_i,
  input  logic            rev_i,
  input  logic            raw_i,
  input  logic            pos_i,
  input  logic            neg_i,
  output logic [NPIN-1:0] pin_o
);
  always_comb begin
    pin_o = '0;
    if (is_quad(mode_i)) begin
      if (rev_i) begin
        pin_o[2] = 1'b1;
        pin_o[1] = raw_i;
      end else begin
        pin_o[0] = 1'b1;
        pin_o[3] = raw_i;
      end
    end else if (is_dual(mode_i)) begin
      pin_o[0] = pos_i;
      pin_o[1] = neg_i;
    end else begin
      pin_o[0] = raw_i;
    end
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int unsigned PER_W  = 8,
  parameter int unsigned FRAC_W = 2,
  parameter int unsigned DB_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              ctl_func,
  input  logic [1:0]              out_mode,
  input  logic                    bridge_rev,
  input  logic [PER_W-1:0]        period_i,
  input  logic [PER_W+FRAC_W-1:0] duty_i,
  input  logic [DB_W-1:0]         dband_i,
  input  logic                    shdn_i,
  output logic [NPIN-1:0]         pwm_o,
  output logic [NPIN-1:0]         pwm_oe
);
  logic [1:0]      rst_sync;
  logic            rst_s;
  logic            run, raw, wrap, pos, neg;
  logic            halt_q, halt_d;
  logic [NPIN-1:0] steer, out_d, oe_d;

  // reset asserts at once, deasserts two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign run = (ctl_func[3:2] == 2'b11);

  pwm_timebase #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst_n(rst_s), .run(run), .period_i(period_i),
    .duty_i(duty_i), .raw_o(raw), .wrap_o(wrap)
  );

  pwm_deadband #(.DB_W(DB_W)) u_db (
    .clk(clk), .rst_n(rst_s), .raw_i(raw), .dband_i(dband_i),
    .pos_o(pos), .neg_o(neg)
  );

  pwm_outsel u_sel (
    .mode_i(out_mode), .rev_i(bridge_rev), .raw_i(raw),
    .pos_i(pos), .neg_i(neg), .pin_o(steer)
  );

  // shutdown latch: set by the request, cleared only at a rollover
  always_comb begin
    halt_d = halt_q;
    if (shdn_i)    halt_d = 1'b1;
    else if (!run) halt_d = 1'b0;
    else if (wrap) halt_d = 1'b0;
  end

  always_comb begin
    oe_d  = run ? pin_mask(out_mode) : '0;
    out_d = (shdn_i || halt_q || !run) ? '0 : (steer & oe_d);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      halt_q <= 1'b0;
      pwm_o  <= '0;
      pwm_oe <= '0;
    end else begin
      halt_q <= halt_d;
      pwm_o  <= out_d;
      pwm_oe <= oe_d;
    end
  end
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ctl_func,
  input logic [1:0] out_mode,
  input logic       bridge_rev,
  input logic       shdn_i,
  input logic [3:0] pwm_o,
  input logic [3:0] pwm_oe
);
  logic on;
  assign on = (ctl_func[3:2] == 2'b11);

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (pwm_o == 4'b0000 && pwm_oe == 4'b0000));

  a_r2_dual_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (on && out_mode == 2'b10) |=> pwm_oe == 4'b0011);

  a_r2_quad_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (on && out_mode[0]) |=> pwm_oe == 4'b1111);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_o[0] && pwm_o[1]));

  a_r7_fwd_mid_low: assert property (@(posedge clk) disable iff (!rst_n)
    (on && out_mode[0] && !bridge_rev) |=> (!pwm_o[1] && !pwm_o[2]));

  a_r8_rev_side_low: assert property (@(posedge clk) disable iff (!rst_n)
    (on && out_mode[0] && bridge_rev) |=> (!pwm_o[0] && !pwm_o[3]));

  a_r9_shdn_low: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |=> pwm_o == 4'b0000);

  a_r11_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o & ~pwm_oe) == 4'b0000);
endmodule

bind pwm_steer pwm_steer_chk u_chk (.*);

// File: tb/pwm_steer_test.sv
`timescale 1ns/1ps
module pwm_steer_test;
  typedef struct packed {
    logic [1:0]  mode;
    logic        rev;
    logic [7:0]  per;
    logic [9:0]  duty;
    logic [5:0]  db;
    logic [10:0] ea, eb, ec, ed;
    logic [3:0]  eoe;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 8'd9, 10'd13, 6'd0, 11'd13, 11'd0,  11'd0,  11'd0,  4'b0001},
    '{2'b00, 1'b0, 8'd9, 10'd0,  6'd0, 11'd0,  11'd0,  11'd0,  11'd0,  4'b0001},
    '{2'b00, 1'b0, 8'd9, 10'd50, 6'd0, 11'd40, 11'd0,  11'd0,  11'd0,  4'b0001},
    '{2'b10, 1'b0, 8'd9, 10'd20, 6'd3, 11'd17, 11'd17, 11'd0,  11'd0,  4'b0011},
    '{2'b10, 1'b0, 8'd9, 10'd10, 6'd0, 11'd10, 11'd30, 11'd0,  11'd0,  4'b0011},
    '{2'b10, 1'b0, 8'd4, 10'd6,  6'd5, 11'd1,  11'd9,  11'd0,  11'd0,  4'b0011},
    '{2'b01, 1'b0, 8'd9, 10'd15, 6'd0, 11'd40, 11'd0,  11'd0,  11'd15, 4'b1111},
    '{2'b11, 1'b1, 8'd9, 10'd15, 6'd0, 11'd0,  11'd15, 11'd40, 11'd0,  4'b1111},
    '{2'b11, 1'b0, 8'd7, 10'd1,  6'd0, 11'd32, 11'd0,  11'd0,  11'd1,  4'b1111},
    '{2'b01, 1'b1, 8'd7, 10'd31, 6'd0, 11'd0,  11'd31, 11'd32, 11'd0,  4'b1111}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ctl_func;
  logic [1:0] out_mode;
  logic       bridge_rev;
  logic [7:0] period_i;
  logic [9:0] duty_i;
  logic [5:0] dband_i;
  logic       shdn_i;
  logic [3:0] pwm_o, pwm_oe;

  int checks = 0;
  int errors = 0;
  int overlap = 0;
  int cnt[4];

  always #2 clk = ~clk;

  pwm_steer uut (
    .clk(clk), .rst_n(rst_n), .ctl_func(ctl_func), .out_mode(out_mode),
    .bridge_rev(bridge_rev), .period_i(period_i), .duty_i(duty_i),
    .dband_i(dband_i), .shdn_i(shdn_i), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_high(input int n);
    for (int p = 0; p < 4; p++) cnt[p] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int p = 0; p < 4; p++) if (pwm_o[p]) cnt[p]++;
      if (pwm_o[0] && pwm_o[1]) overlap++;
    end
  endtask

  task automatic sync_rise();
    int guard = 0;
    @(negedge clk);
    while (pwm_o[0] && guard < 500) begin @(negedge clk); guard++; end
    while (!pwm_o[0] && guard < 500) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0; ctl_func = 4'b1100; out_mode = 2'b01; bridge_rev = 1'b0;
    period_i = 8'd9; duty_i = 10'd13; dband_i = 6'd0; shdn_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 pwm_o in reset", int'(pwm_o), 0);
    chk("R10 pwm_oe in reset", int'(pwm_oe), 0);
    ctl_func = 4'b0000;
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 pwm_oe after reset, off", int'(pwm_oe), 0);
    count_high(40);
    chk("R10 pin A high cycles while off", cnt[0], 0);

    // function field not 11xx keeps everything quiet (R1)
    ctl_func = 4'b1011;
    count_high(60);
    chk("R1 pwm_oe with func 1011", int'(pwm_oe), 0);
    chk("R1 pin A high cycles", cnt[0], 0);
    chk("R1 pin D high cycles", cnt[3], 0);

    // table walk: counts over exactly one period
    ctl_func = 4'b1100;
    for (int v = 0; v < NV; v++) begin
      out_mode = TBL[v].mode; bridge_rev = TBL[v].rev; period_i = TBL[v].per;
      duty_i = TBL[v].duty; dband_i = TBL[v].db;
      repeat (100) @(negedge clk);
      count_high(4 * (int'(TBL[v].per) + 1));
      if (TBL[v].mode == 2'b00)      tag = "R3 R5 R11";
      else if (TBL[v].mode == 2'b10) tag = "R6 R11";
      else if (TBL[v].rev)           tag = "R8";
      else                           tag = "R7";
      chk($sformatf("%s vec%0d pin A", tag, v), cnt[0], int'(TBL[v].ea));
      chk($sformatf("%s vec%0d pin B", tag, v), cnt[1], int'(TBL[v].eb));
      chk($sformatf("%s vec%0d pin C", tag, v), cnt[2], int'(TBL[v].ec));
      chk($sformatf("%s vec%0d pin D", tag, v), cnt[3], int'(TBL[v].ed));
      chk($sformatf("R2 vec%0d pwm_oe", v), int'(pwm_oe), int'(TBL[v].eoe));
    end
    chk("R6 cycles with A and B both high", overlap, 0);

    // duty written in mid-period waits for rollover (R4)
    out_mode = 2'b00; period_i = 8'd9; duty_i = 10'd13; dband_i = 6'd0;
    repeat (100) @(negedge clk);
    sync_rise();
    repeat (20) @(negedge clk);
    duty_i = 10'd30;
    count_high(15);
    chk("R4 pin A high rest of period after duty write", cnt[0], 0);
    count_high(40);
    chk("R4 pin A high in next period", cnt[0], 30);

    // shutdown while A is high (R9)
    duty_i = 10'd13;
    repeat (100) @(negedge clk);
    sync_rise();
    shdn_i = 1'b1;
    @(negedge clk);
    chk("R9 pin A one clock after shutdown", int'(pwm_o[0]), 0);
    repeat (2) @(negedge clk);
    shdn_i = 1'b0;
    count_high(30);
    chk("R9 pin A stays low until period start", cnt[0], 0);
    count_high(40);
    chk("R9 pin A high cycles after resume", cnt[0], 13);

    // shutdown in bridge mode pulls the held-high corner low too
    out_mode = 2'b01; bridge_rev = 1'b0;
    repeat (100) @(negedge clk);
    shdn_i = 1'b1;
    count_high(40);
    chk("R9 bridge pins during shutdown", cnt[0] + cnt[3], 0);
    shdn_i = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule